// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block sits on the slave side of a management link and lets a host that can only issue 16-bit clause-22 reads and writes reach a space of 32-bit internal registers. An upstream deserialiser has already turned each serial frame into a one-cycle access strobe. That strobe carries a direction, a 5-bit PHY address, a 5-bit register number and 16 bits of write data. The bridge turns these strobes into word accesses on a simple internal register bus with address, read strobe, write strobe, write data and read data.

The 32-bit word address is built from two sources. A page register supplies the upper bits. The PHY address and register number of the access supply the rest. Each internal register appears to the host as two 16-bit halves. Software writes the high half first and the low half second, and the low-half write commits all 32 bits in one bus cycle. Software reads the low half first, which fetches the whole word and keeps its upper half for the high-half read that follows. This way the two halves always come from the same fetch.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset the page register is zero, `mdio_rvalid` is low, and neither `reg_we` nor `reg_re` is asserted.
- R2: A write to PHY 0x1F, register 0x10 loads `mdio_wdata[8:0]` into the 9-bit page register and ignores the upper data bits. A read of that location returns the page value zero-extended to 16 bits.
- R3: For a data access, the word address on `reg_addr` is {page, PHY[2:0], register[4:1]}. This is the byte address shifted right by two.
- R4: Data accesses use PHY addresses 0x10 to 0x17. An odd register number selects the high half of a word, and an even register number selects the low half.
- R5: A high-half write (odd register) causes no bus activity. It only stores its 16 bits in a holding register, which keeps that value until the next high-half write.
- R6: A low-half write asserts `reg_we` in the same cycle as the strobe, for exactly that cycle. `reg_wdata` is {held high half, `mdio_wdata`}.
- R7: A low-half read asserts `reg_re` in the strobe cycle and returns `reg_rdata[15:0]`. It also stores `reg_rdata[31:16]` as a snapshot.
- R8: A high-half read asserts no bus strobe and returns the snapshot from the most recent low-half read, even if the register has changed since then.
- R9: An access to any PHY address outside 0x10 to 0x17 is not claimed, and neither is an access to PHY 0x1F with a register number other than 0x10. Such a read returns 0xFFFF. Such a write changes nothing and causes no bus activity.
- R10: Every read strobe produces `mdio_rvalid` high, with its data on `mdio_rdata`, in exactly the next cycle. Write strobes and idle cycles produce `mdio_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_valid | input | 1 | One-cycle strobe for a decoded management access |
| mdio_write | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | PHY address of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rvalid | output | 1 | Read response valid, one cycle after a read strobe |
| mdio_rdata | output | 16 | Read response data |
| reg_addr | output | 16 | Internal word address (PAGE_W+7 bits) |
| reg_we | output | 1 | Internal 32-bit write strobe |
| reg_re | output | 1 | Internal 32-bit read strobe |
| reg_wdata | output | 32 | Internal write data |
| reg_rdata | input | 32 | Internal read data, valid in the cycle `reg_re` is high |

## Verification
A page register holding a wrong value shows up at once as a wrong `reg_addr` on the next data access. A holding register that is stale or cleared shows up as wrong upper bits of `reg_wdata` on the next low-half write. A snapshot that is wrong, or that is refreshed at the wrong moment, only becomes visible on the next high-half read. For that reason the bench changes register contents between a low-half read and its high-half read. A wrong claim decision shows up as a bus strobe, or as data other than 0xFFFF, in the cycle of the access or the cycle after it.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int PHY_W    = 5;
    localparam int REGN_W   = 5;
    localparam int SUB_W    = 3;               // PHY bits folded into the address
    localparam int LOW_W    = REGN_W - 1;      // register bits folded into the address
    localparam int FOLD_W   = SUB_W + LOW_W;   // address bits below the page

    localparam logic [PHY_W-1:0]  PAGE_PHY  = 5'h1F;
    localparam logic [REGN_W-1:0] PAGE_REGN = 5'h10;
    localparam logic [1:0]        DATA_WIN  = 2'b10;   // PHY[4:3] of 0x10..0x17
    localparam logic [HALF_W-1:0] NO_CLAIM  = 16'hFFFF;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_PAGE = 2'd1,
        K_LOW  = 2'd2,
        K_HIGH = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             active;
        logic             write;
        acc_kind_e        kind;
        logic [FOLD_W-1:0] fold;
    } acc_req_t;

    function automatic acc_kind_e classify(input logic [PHY_W-1:0] phy,
                                           input logic [REGN_W-1:0] regn);
        if (phy[PHY_W-1 -: 2] == DATA_WIN)
            return regn[0] ? K_HIGH : K_LOW;
        else if (phy == PAGE_PHY && regn == PAGE_REGN)
            return K_PAGE;
        else
            return K_NONE;
    endfunction

    function automatic logic [FOLD_W-1:0] fold_bits(input logic [PHY_W-1:0] phy,
                                                    input logic [REGN_W-1:0] regn);
        return {phy[SUB_W-1:0], regn[REGN_W-1:1]};
    endfunction

endpackage

// File: rtl/mrb_access_decode.sv
module mrb_access_decode
    import mrb_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REGN_W-1:0] regn,
    output acc_req_t          req
);

    always_comb begin
        req.active = valid;
        req.write  = write;
        req.kind   = valid ? classify(phy, regn) : K_NONE;
        req.fold   = fold_bits(phy, regn);
    end

    // R9: the page location is the only claimed spot outside the data window
    always_comb begin
        if (valid && req.kind == K_PAGE)
            a_r9_page_only_at_fixed_spot: assert (phy == PAGE_PHY && regn == PAGE_REGN);
    end

endmodule

// File: rtl/mrb_page_reg.sv
module mrb_page_reg
    import mrb_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);

    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (wr_en)
            page <= wdata[PAGE_W-1:0];
    end

endmodule

// File: rtl/mrb_half_buffer.sv
module mrb_half_buffer
    import mrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_wr,
    input  logic [HALF_W-1:0] hi_wdata,
    input  logic              lo_rd,
    input  logic [HALF_W-1:0] rd_upper,
    output logic [HALF_W-1:0] hold_hi,
    output logic [HALF_W-1:0] snap_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_hi <= '0;
            snap_hi <= '0;
        end else begin
            if (hi_wr)
                hold_hi <= hi_wdata;
            if (lo_rd)
                snap_hi <= rd_upper;
        end
    end

    // R8: the snapshot only moves on a low-half read
    a_r8_snapshot_stable: assert property (@(posedge clk) disable iff (rst)
        !lo_rd |=> $stable(snap_hi));

    // R5: the held half only moves on a high-half write
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !hi_wr |=> $stable(hold_hi));

endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
    import mrb_pkg::*;
#(
    parameter  int PAGE_W  = 9,
    localparam int WADDR_W = PAGE_W + FOLD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mdio_valid,
    input  logic               mdio_write,
    input  logic [PHY_W-1:0]   mdio_phy,
    input  logic [REGN_W-1:0]  mdio_reg,
    input  logic [HALF_W-1:0]  mdio_wdata,
    output logic               mdio_rvalid,
    output logic [HALF_W-1:0]  mdio_rdata,
    output logic [WADDR_W-1:0] reg_addr,
    output logic               reg_we,
    output logic               reg_re,
    output logic [WORD_W-1:0]  reg_wdata,
    input  logic [WORD_W-1:0]  reg_rdata
);

    acc_req_t          req;
    logic [PAGE_W-1:0] page;
    logic [HALF_W-1:0] hold_hi;
    logic [HALF_W-1:0] snap_hi;
    logic              page_wr;
    logic              hi_wr;
    logic              lo_rd;
    logic [HALF_W-1:0] rd_mux;

    mrb_access_decode u_dec (
        .valid (mdio_valid),
        .write (mdio_write),
        .phy   (mdio_phy),
        .regn  (mdio_reg),
        .req   (req)
    );

    assign page_wr = req.active &&  req.write && req.kind == K_PAGE;
    assign hi_wr   = req.active &&  req.write && req.kind == K_HIGH;
    assign lo_rd   = req.active && !req.write && req.kind == K_LOW;

    mrb_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst   (rst),
        .wr_en (page_wr),
        .wdata (mdio_wdata),
        .page  (page)
    );

    mrb_half_buffer u_half (
        .clk      (clk),
        .rst      (rst),
        .hi_wr    (hi_wr),
        .hi_wdata (mdio_wdata),
        .lo_rd    (lo_rd),
        .rd_upper (reg_rdata[WORD_W-1:HALF_W]),
        .hold_hi  (hold_hi),
        .snap_hi  (snap_hi)
    );

    // Internal bus: address folded from page and access fields
    assign reg_addr  = {page, req.fold};
    assign reg_we    = req.active && req.write && req.kind == K_LOW;
    assign reg_re    = lo_rd;
    assign reg_wdata = {hold_hi, mdio_wdata};

    always_comb begin
        unique case (req.kind)
            K_PAGE:  rd_mux = HALF_W'(page);
            K_LOW:   rd_mux = reg_rdata[HALF_W-1:0];
            K_HIGH:  rd_mux = snap_hi;
            default: rd_mux = NO_CLAIM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdio_rvalid <= 1'b0;
            mdio_rdata  <= '0;
        end else begin
            mdio_rvalid <= mdio_valid && !mdio_write;
            if (mdio_valid && !mdio_write)
                mdio_rdata <= rd_mux;
        end
    end

    // R6: one bus operation at a time
    a_r6_single_op: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    // R7: a low-half read in the data window always fetches
    a_r7_low_read_fetches: assert property (@(posedge clk) disable iff (rst)
        mdio_valid && !mdio_write && mdio_phy[4:3] == 2'b10 && !mdio_reg[0] |-> reg_re);

    // R5: a high-half write never strobes the bus
    a_r5_high_write_silent: assert property (@(posedge clk) disable iff (rst)
        mdio_valid && mdio_write && mdio_reg[0] |-> !reg_we && !reg_re);

    // R10: response exactly one cycle after each read strobe
    a_r10_resp_after_read: assert property (@(posedge clk) disable iff (rst)
        mdio_valid && !mdio_write |=> mdio_rvalid);
    a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !(mdio_valid && !mdio_write) |=> !mdio_rvalid);

    // R9: unclaimed reads return all ones
    a_r9_unclaimed_ones: assert property (@(posedge clk) disable iff (rst)
        mdio_valid && !mdio_write && mdio_phy[4:3] != 2'b10 &&
        !(mdio_phy == 5'h1F && mdio_reg == 5'h10) |=> mdio_rdata == 16'hFFFF);

    // R2: page changes only on a write at the page location
    a_r2_page_stable: assert property (@(posedge clk) disable iff (rst)
        !(mdio_valid && mdio_write && mdio_phy == 5'h1F && mdio_reg == 5'h10)
        |=> $stable(page));

endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdio_valid = 1'b0;
    logic        mdio_write = 1'b0;
    logic [4:0]  mdio_phy = '0;
    logic [4:0]  mdio_reg = '0;
    logic [15:0] mdio_wdata = '0;
    logic        mdio_rvalid;
    logic [15:0] mdio_rdata;
    logic [15:0] reg_addr;
    logic        reg_we;
    logic        reg_re;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    // bench register space and reference state
    logic [31:0] mem [int];
    int          m_page = 0;
    logic [15:0] m_hold = '0;
    logic [15:0] m_snap = '0;

    always #4 clk = ~clk;   // 125 MHz

    mdio_reg_bridge uut (
        .clk(clk), .rst(rst),
        .mdio_valid(mdio_valid), .mdio_write(mdio_write),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] peek(input int a);
        if (mem.exists(a)) return mem[a];
        return 32'h5A00_0000 ^ (a * 32'h0001_0003);
    endfunction

    always @* reg_rdata = peek(int'(reg_addr));

    always @(posedge clk) if (!rst && reg_we) mem[int'(reg_addr)] = reg_wdata;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // idle cycles: no bus strobes, no response (compared every clock)
    always @(negedge clk) begin
        if (!rst && !mdio_valid) begin
            chk(!reg_we && !reg_re, "R1", "idle bus", {reg_we, reg_re}, 0);
        end
    end

    // One access: drive at negedge, check bus before the edge, response after.
    task automatic access(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input string rq);
        int          kind;  // 0 none, 1 page, 2 low, 3 high
        int          wa;
        logic [15:0] exp_r;
        logic [31:0] word;
        @(negedge clk);
        mdio_valid = 1'b1; mdio_write = wr; mdio_phy = phy; mdio_reg = rg; mdio_wdata = d;
        if (phy >= 5'h10 && phy <= 5'h17) kind = rg[0] ? 3 : 2;
        else if (phy == 5'h1F && rg == 5'h10) kind = 1;
        else kind = 0;
        wa = m_page * 128 + (phy % 8) * 16 + rg / 2;
        #1;
        chk(reg_we == (wr && kind == 2), rq, "reg_we", reg_we, wr && kind == 2);
        chk(reg_re == (!wr && kind == 2), rq, "reg_re", reg_re, !wr && kind == 2);
        if (kind >= 2)
            chk(reg_addr == wa[15:0], "R3", "reg_addr", reg_addr, wa);
        if (wr && kind == 2)
            chk(reg_wdata == {m_hold, d}, "R6", "reg_wdata", reg_wdata, {m_hold, d});
        word  = peek(wa);
        exp_r = 16'hFFFF;
        case (kind)
            1: exp_r = 16'(m_page);
            2: exp_r = word[15:0];
            3: exp_r = m_snap;
            default: ;
        endcase
        @(posedge clk);
        if (wr) begin
            if (kind == 1) m_page = int'(d[8:0]);
            if (kind == 3) m_hold = d;
        end else if (kind == 2) begin
            m_snap = word[31:16];
        end
        #1;
        mdio_valid = 1'b0;
        chk(mdio_rvalid == !wr, "R10", "rvalid", mdio_rvalid, !wr);
        if (!wr)
            chk(mdio_rdata == exp_r, rq, "rdata", mdio_rdata, exp_r);
    endtask

    task automatic wr32(input int byte_a, input logic [31:0] v, input string rq);
        int wa = byte_a / 4;
        access(1, 5'h1F, 5'h10, 16'(wa / 128), "R2");
        access(1, 5'(16 + (wa / 16) % 8), 5'(((wa % 16) * 2) + 1), v[31:16], rq);
        access(1, 5'(16 + (wa / 16) % 8), 5'((wa % 16) * 2), v[15:0], rq);
    endtask

    task automatic rd32(input int byte_a, input string rq);
        int wa = byte_a / 4;
        access(1, 5'h1F, 5'h10, 16'(wa / 128), "R2");
        access(0, 5'(16 + (wa / 16) % 8), 5'((wa % 16) * 2), 16'h0, rq);
        access(0, 5'(16 + (wa / 16) % 8), 5'(((wa % 16) * 2) + 1), 16'h0, rq);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!mdio_rvalid, "R1", "rvalid in reset", mdio_rvalid, 0);
        @(negedge clk); rst = 1'b0;
        chk(!reg_we && !reg_re, "R1", "bus after reset", {reg_we, reg_re}, 0);
        access(0, 5'h1F, 5'h10, 16'h0, "R1");                 // page reads zero

        // R2: page load uses only 9 bits
        access(1, 5'h1F, 5'h10, 16'hFE37, "R2");
        access(0, 5'h1F, 5'h10, 16'h0, "R2");

        // R4/R6: full writes then reads across the folded fields
        wr32(32'h0000_0000, 32'h1122_3344, "R6");
        wr32(32'h0000_01FC, 32'hDEAD_BEEF, "R4");
        wr32(32'h0003_FFFC, 32'hCAFE_F00D, "R3");
        wr32(32'h0001_2344, 32'h0BAD_C0DE, "R3");
        rd32(32'h0000_0000, "R7");
        rd32(32'h0000_01FC, "R7");
        rd32(32'h0003_FFFC, "R4");
        rd32(32'h0001_2344, "R7");
        rd32(32'h0000_2000, "R7");  // untouched location

        // R5: held half persists across several low writes
        access(1, 5'h12, 5'h03, 16'hAAAA, "R5");
        access(1, 5'h12, 5'h02, 16'h0001, "R5");
        access(1, 5'h13, 5'h06, 16'h0002, "R5");
        rd32(32'h0000_0000 + (((m_page * 128) + 2 * 16 + 1) * 4), "R5");

        // R8: snapshot survives a change of the register between halves
        rd32(32'h0000_0100, "R7");
        mem[64] = 32'h7777_8888;
        access(0, 5'h14, 5'h01, 16'h0, "R8");
        access(0, 5'h14, 5'h00, 16'h0, "R8");
        access(0, 5'h14, 5'h01, 16'h0, "R8");

        // R9: unclaimed reads and writes
        access(0, 5'h00, 5'h00, 16'h0, "R9");
        access(0, 5'h18, 5'h02, 16'h0, "R9");
        access(0, 5'h1F, 5'h11, 16'h0, "R9");
        access(0, 5'h0F, 5'h10, 16'h0, "R9");
        access(1, 5'h1F, 5'h11, 16'h0123, "R9");
        access(1, 5'h08, 5'h00, 16'h4567, "R9");
        access(0, 5'h1F, 5'h10, 16'h0, "R9");   // page unchanged
        access(1, 5'h1E, 5'h01, 16'h9999, "R9");
        access(1, 5'h10, 5'h00, 16'h0042, "R9"); // hold unchanged by unclaimed write

        // R10: back-to-back reads each answered next cycle
        access(0, 5'h11, 5'h00, 16'h0, "R10");
        access(0, 5'h11, 5'h01, 16'h0, "R10");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule